// File: doc/BRIEF.md
# Double-Buffered Infopacket Slot Memory

This block holds auxiliary video infopackets for a display transmitter. The store has fifteen slots of nine 32-bit words each. Word 0 of a slot carries the four header bytes, with header byte 0 in bits 7:0. Words 1 to 8 carry the payload. Software reaches the words through an index register and a data register. It loads the index with slot times nine, then writes words one after another, and the index steps forward by one after each write. All software writes land in a pending copy that the transmitter never sees.

Each slot has two request bits. The first is an immediate request, which copies the slot from pending to active in the first cycle in which the update-lock input is low. The second is a frame request, which copies the slot only on a frame-start strobe. Each request bit clears itself in the cycle its copy happens. The transmitter reads active words through a port addressed by slot and word number, with one cycle of latency. A sticky flag records any cycle in which a transmitter read and a software data write happen together.

Top module: `infopkt_store`

## Requirements
- R1: After reset the index is 0, both request vectors are 0, the conflict flag is 0, read data is 0 and every active word reads as 0.
- R2: A register write to address 1 (data) while the index is at most 134 stores the word at the index in the pending copy and raises the index by one. Pending contents never appear at the read port before a commit.
- R3: Index value slot*9+word maps to that slot and word. A read with rdEn high returns the active word on rdData one cycle later. A slot above 14 or a word above 8 returns 0. rdData holds its value while rdEn is low.
- R4: Writing address 2 sets immediate-request bits, one per slot, with bit n standing for slot n. Each set bit copies its slot to active at the first clock edge where updateLock is 0, and clears at that edge.
- R5: Writing address 3 sets frame-request bits, with bit n standing for slot n. These copy their slots only at an edge where frameStart is 1, and they clear there. Neither a low updateLock nor idle cycles move them.
- R6: A data write while the index is 135 or more stores nothing, and the index keeps its value.
- R7: The conflict flag sets when rdEn and a data write occur in the same cycle. It stays set until a write to address 4 with bit 0 at 1. A new conflict in the same cycle as a clear leaves the flag set.
- R8: Request bits act per slot. Several slots may commit at one edge, and writing 0 to a request bit does not cancel a pending request.
- R9: Writing address 0 loads the index from regWdata[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select: 0 index, 1 data, 2 immediate requests, 3 frame requests, 4 status clear |
| regWdata | input | 32 | Register write data |
| frameStart | input | 1 | Single-cycle frame boundary strobe |
| updateLock | input | 1 | Holds immediate commits back while high |
| rdEn | input | 1 | Transmitter read strobe |
| rdSlot | input | 4 | Read slot number |
| rdWord | input | 4 | Read word number within the slot |
| rdData | output | 32 | Active word, valid one cycle after rdEn |
| dataIndex | output | 8 | Current software index |
| immReq | output | 15 | Pending immediate requests, bit n for slot n |
| frameReq | output | 15 | Pending frame requests, bit n for slot n |
| conflict | output | 1 | Sticky read/write conflict flag |

## Verification
A broken index shows up on dataIndex in the cycle after the write. It also shows up later as packet words read back from the wrong slot or word once a commit has run. A commit that starts too early or from the wrong slot appears on rdData on the first read after the faulty edge. The faulty edge is an idle cycle, a locked cycle, or a frame strobe against an immediate-only request. A request bit that fails to clear, or clears too early, shows on immReq or frameReq one cycle after the edge in question. A conflict flag that fails to set, or fails to clear, shows on the next cycle.

// File: rtl/infopkt_pkg.sv
package infopkt_pkg;
  localparam int SLOTS  = 15;
  localparam int WORDS  = 9;
  localparam int DW     = 32;
  localparam int TOTAL  = SLOTS * WORDS;
  localparam int IDX_W  = $clog2(TOTAL + 1);
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam int WORD_W = $clog2(WORDS);
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_INDEX  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IMM    = 3'd2;
  localparam logic [ADDR_W-1:0] A_FRAME  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSlot;
    logic [WORD_W-1:0] wrWord;
    logic [SLOTS-1:0]  commit;
  } strobes_t;
endpackage

// File: rtl/infopkt_ctrl.sv
module infopkt_ctrl
  import infopkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  input  logic              frameStart,
  input  logic              updateLock,
  input  logic              rdEn,
  output strobes_t          stb,
  output logic [IDX_W-1:0]  dataIndex,
  output logic [SLOTS-1:0]  immReq,
  output logic [SLOTS-1:0]  frameReq,
  output logic              conflict
);
  localparam logic [IDX_W-1:0] TOTAL_V = IDX_W'(TOTAL);
  localparam logic [IDX_W-1:0] WORDS_V = IDX_W'(WORDS);

  logic             dataWe, inRange, idxLoad, clrHit, conflictHit;
  logic [SLOTS-1:0] immSet, frameSet, immDone, frameDone;
  logic [IDX_W-1:0] quot, remd;

  assign dataWe      = regWe && (regAddr == A_DATA);
  assign idxLoad     = regWe && (regAddr == A_INDEX);
  assign inRange     = dataIndex < TOTAL_V;
  assign clrHit      = regWe && (regAddr == A_STATUS) && regWdata[0];
  assign conflictHit = rdEn && dataWe;

  assign immSet    = (regWe && regAddr == A_IMM)   ? regWdata[SLOTS-1:0] : '0;
  assign frameSet  = (regWe && regAddr == A_FRAME) ? regWdata[SLOTS-1:0] : '0;
  assign immDone   = updateLock ? '0 : immReq;
  assign frameDone = frameStart ? frameReq : '0;

  always_comb begin
    quot       = dataIndex / WORDS_V;
    remd       = dataIndex % WORDS_V;
    stb.wrEn   = dataWe && inRange;
    stb.wrSlot = quot[SLOT_W-1:0];
    stb.wrWord = remd[WORD_W-1:0];
    stb.commit = immDone | frameDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataIndex <= '0;
      immReq    <= '0;
      frameReq  <= '0;
      conflict  <= 1'b0;
    end else begin
      if (idxLoad)
        dataIndex <= regWdata[IDX_W-1:0];
      else if (dataWe && inRange)
        dataIndex <= dataIndex + 1'b1;
      immReq   <= (immReq & ~immDone) | immSet;
      frameReq <= (frameReq & ~frameDone) | frameSet;
      conflict <= conflictHit | (conflict & ~clrHit);
    end
  end

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe && dataIndex < TOTAL_V) |=> dataIndex == $past(dataIndex) + 1'b1);
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe && dataIndex >= TOTAL_V) |=> $stable(dataIndex));
  p_imm_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!updateLock && !(regWe && regAddr == A_IMM)) |=> immReq == '0);
  p_frame_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !(regWe && regAddr == A_FRAME)) |=> frameReq == '0);
  p_frame_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ((~frameReq & $past(frameReq)) == '0));
  p_conflict_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (conflict && !(regWe && regAddr == A_STATUS && regWdata[0])) |=> conflict);
  p_conflict_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regWe && regAddr == A_DATA) |=> conflict);
endmodule

// File: rtl/infopkt_mem.sv
module infopkt_mem
  import infopkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DW-1:0]     wrData,
  input  logic              rdEn,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [WORD_W-1:0] rdWord,
  output logic [DW-1:0]     rdData
);
  localparam logic [SLOT_W-1:0] SLOTS_V = SLOT_W'(SLOTS);
  localparam logic [WORD_W-1:0] WORDS_V = WORD_W'(WORDS);

  logic [DW-1:0] slotRd [SLOTS];
  logic          rdOk;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DW-1:0] pend [WORDS];
    logic [DW-1:0] act  [WORDS];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < WORDS; w++) begin
          pend[w] <= '0;
          act[w]  <= '0;
        end
      end else begin
        if (stb.wrEn && stb.wrSlot == SLOT_W'(s))
          pend[stb.wrWord] <= wrData;
        if (stb.commit[s])
          act <= pend;
      end
    end

    assign slotRd[s] = (rdWord < WORDS_V) ? act[rdWord] : '0;
  end

  assign rdOk = (rdSlot < SLOTS_V) && (rdWord < WORDS_V);

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (rdEn)
      rdData <= rdOk ? slotRd[rdSlot] : '0;
  end

  p_rd_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdOk) |=> rdData == '0);
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

// File: rtl/infopkt_store.sv
module infopkt_store
  import infopkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  input  logic              frameStart,
  input  logic              updateLock,
  input  logic              rdEn,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [WORD_W-1:0] rdWord,
  output logic [DW-1:0]     rdData,
  output logic [IDX_W-1:0]  dataIndex,
  output logic [SLOTS-1:0]  immReq,
  output logic [SLOTS-1:0]  frameReq,
  output logic              conflict
);
  strobes_t stb;

  infopkt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .frameStart(frameStart), .updateLock(updateLock),
    .rdEn(rdEn), .stb(stb), .dataIndex(dataIndex), .immReq(immReq),
    .frameReq(frameReq), .conflict(conflict)
  );

  infopkt_mem u_mem (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWdata), .rdEn(rdEn),
    .rdSlot(rdSlot), .rdWord(rdWord), .rdData(rdData)
  );
endmodule

// File: tb/infopkt_store_test.sv
module infopkt_store_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        frameStart = 1'b0;
  logic        updateLock = 1'b1;
  logic        rdEn = 1'b0;
  logic [3:0]  rdSlot = '0;
  logic [3:0]  rdWord = '0;
  logic [31:0] rdData;
  logic [7:0]  dataIndex;
  logic [14:0] immReq, frameReq;
  logic        conflict;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  infopkt_store uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .frameStart(frameStart), .updateLock(updateLock),
    .rdEn(rdEn), .rdSlot(rdSlot), .rdWord(rdWord), .rdData(rdData),
    .dataIndex(dataIndex), .immReq(immReq), .frameReq(frameReq),
    .conflict(conflict)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(int g, int s, int w);
    return 32'(g) * 32'h0100_0000 + 32'(s) * 32'h0001_0000 + 32'(w) * 32'h100 + 32'h5A;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(int s, int w, output logic [31:0] q);
    rdEn = 1'b1; rdSlot = 4'(s); rdWord = 4'(w);
    @(negedge clk);
    rdEn = 1'b0;
    q = rdData;
  endtask

  task automatic fillSlot(int s, int g);
    wr(3'd0, 32'(s * 9));
    for (int w = 0; w < 9; w++) wr(3'd1, pat(g, s, w));
  endtask

  task automatic checkSlot(string req, int s, int g);
    logic [31:0] q;
    for (int w = 0; w < 9; w++) begin
      rd(s, w, q);
      check(req, q, pat(g, s, w));
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 index", 32'(dataIndex), 0);
    check("R1 immReq", 32'(immReq), 0);
    check("R1 frameReq", 32'(frameReq), 0);
    check("R1 conflict", 32'(conflict), 0);
    check("R1 rdData", rdData, 0);
    for (int s = 0; s < 15; s++) begin
      rd(s, s % 9, q);
      check("R1 active zero", q, 0);
    end

    // R9 load index, R2 fill all slots by auto-increment
    wr(3'd0, 32'd0);
    check("R9 index load", 32'(dataIndex), 0);
    for (int i = 0; i < 135; i++) begin
      wr(3'd1, pat(1, i / 9, i % 9));
      check("R2 index step", 32'(dataIndex), 32'(i + 1));
    end
    rd(0, 0, q);
    check("R2 pending hidden", q, 0);
    // R6 writes past the end
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd1, 32'hFEED_F00D);
    check("R6 index holds", 32'(dataIndex), 135);

    // R5 frame commit of all slots
    wr(3'd3, 32'h0000_7FFF);
    check("R5 frameReq set", 32'(frameReq), 32'h7FFF);
    updateLock = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 frameReq waits", 32'(frameReq), 32'h7FFF);
    rd(3, 0, q);
    check("R5 no early commit", q, 0);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    check("R5 frameReq clears", 32'(frameReq), 0);
    // R3 full sweep of active words
    for (int s = 0; s < 15; s++) checkSlot("R3 sweep", s, 1);
    rd(15, 0, q);
    check("R3 slot out of range", q, 0);
    rd(2, 4, q);
    check("R3 read", q, pat(1, 2, 4));
    rd(0, 9, q);
    check("R3 word out of range", q, 0);
    rd(2, 4, q);
    repeat (2) @(negedge clk);
    rdSlot = 4'd5;
    @(negedge clk);
    check("R3 hold without rdEn", rdData, pat(1, 2, 4));

    // R4 immediate commit waits for lock low, ignores frame strobe
    updateLock = 1'b1;
    fillSlot(7, 2);
    wr(3'd2, 32'h0000_0080);
    repeat (3) @(negedge clk);
    check("R4 immReq held by lock", 32'(immReq), 32'h80);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    check("R4 frame strobe ignored", 32'(immReq), 32'h80);
    rd(7, 0, q);
    check("R4 old data while locked", q, pat(1, 7, 0));
    updateLock = 1'b0;
    @(negedge clk);
    check("R4 immReq clears", 32'(immReq), 0);
    checkSlot("R4 committed", 7, 2);
    checkSlot("R8 neighbour untouched", 6, 1);

    // R8 two slots committing together; writing 0 does not cancel
    updateLock = 1'b1;
    fillSlot(0, 3);
    fillSlot(14, 3);
    check("R2 last slot index", 32'(dataIndex), 135);
    wr(3'd2, 32'h0000_4001);
    wr(3'd2, 32'h0000_0000);
    check("R8 zero write keeps", 32'(immReq), 32'h4001);
    updateLock = 1'b0;
    @(negedge clk);
    check("R8 both cleared", 32'(immReq), 0);
    checkSlot("R8 slot0", 0, 3);
    checkSlot("R8 slot14", 14, 3);
    wr(3'd3, 32'h0000_0004);
    wr(3'd3, 32'h0000_0000);
    check("R8 frame zero write keeps", 32'(frameReq), 32'h4);

    // R7 conflict flag
    check("R7 idle clear", 32'(conflict), 0);
    wr(3'd0, 32'd20);
    rdEn = 1'b1; rdSlot = 4'd1; rdWord = 4'd0;
    wr(3'd1, 32'h1234_5678);
    rdEn = 1'b0;
    check("R7 set", 32'(conflict), 1);
    repeat (3) @(negedge clk);
    check("R7 sticky", 32'(conflict), 1);
    wr(3'd4, 32'h0000_0000);
    check("R7 bit0 zero no clear", 32'(conflict), 1);
    wr(3'd4, 32'h0000_0001);
    check("R7 cleared", 32'(conflict), 0);
    rdEn = 1'b1;
    wr(3'd1, 32'h0);
    rdEn = 1'b0;
    wr(3'd4, 32'h1);
    check("R7 cleared again", 32'(conflict), 0);
    rdEn = 1'b1;
    wr(3'd1, 32'h0);
    check("R7 set before race", 32'(conflict), 1);
    wr(3'd4, 32'h1);
    rdEn = 1'b1;
    regWe = 1'b1; regAddr = 3'd1; regWdata = 32'h0;
    @(negedge clk);
    regWe = 1'b0; rdEn = 1'b0;
    check("R7 plain clear then set", 32'(conflict), 1);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule